// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small data cache for byte-wide loads and stores. It sits between a processor-side request port and a next-level memory port that moves whole 8-byte blocks. Each 8-bit address splits into a tag, a set index and a byte offset. The two ways of the selected set are compared in parallel, and a hit is answered on the cycle after acceptance.

On a miss the cache stalls the processor port and picks a victim way. An invalid way is taken first. When both ways are valid, the way used least recently in that set is taken. A modified victim is written to the next level in full, and then the missing block is fetched. The stalled request is then replayed against the filled line. Stores that miss allocate the block in the same way that loads do, and their byte is merged into the filled block. Only one miss is handled at a time.

Top module: `wb_cache2`

## Requirements
- R1: After reset every way is invalid and clean: `core_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the first access to any block misses.
- R2: An address splits into tag = bits 7:5, set = bits 4:3 and byte offset = bits 2:0. The next-level block address is bits 7:3 of the byte address, and in `mem_rdata`/`mem_req_wdata` byte k occupies bits 8k+7:8k.
- R3: An accepted access whose tag matches a valid way in its set gives `rsp_valid` on the next cycle, with no next-level request. For a load, `rsp_rdata` is the current byte at that address.
- R4: On a miss, `core_ready` stays 0 from acceptance until the response. Exactly one fill request is made for the missing block. `rsp_valid` rises two cycles after the cycle in which the fill handshake (`mem_req_valid && mem_ready`) completes.
- R5: A store marks its block dirty. A dirty block reaches the next level only when it is evicted, as one write request (`mem_req_write`=1) that carries its current 8 bytes. This request is issued before the fill for the new block.
- R6: A store that misses allocates the block exactly as a load miss does, and its byte is then written into the filled block. Later loads return the stored value.
- R7: A victim is chosen as follows: way 0 if it is invalid, else way 1 if it is invalid, else the way in that set that was accessed less recently. Both hits and replayed misses count as accesses.
- R8: Evicting a clean block causes no write request.
- R9: While `mem_req_valid` is 1 and `mem_ready` is 0, the request stays asserted, and its address and direction do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Processor request present |
| core_write | input | 1 | 1 = store, 0 = load |
| core_addr | input | 8 | Byte address |
| core_wdata | input | 8 | Store byte |
| core_ready | output | 1 | Request accepted when high with core_valid |
| rsp_valid | output | 1 | Access completed this cycle |
| rsp_rdata | output | 8 | Load byte (store byte for stores) |
| mem_req_valid | output | 1 | Next-level request |
| mem_req_write | output | 1 | 1 = write-back, 0 = fill |
| mem_req_addr | output | 5 | Block address |
| mem_req_wdata | output | 64 | Block being written back |
| mem_ready | input | 1 | Next level accepts; fill data valid this cycle |
| mem_rdata | input | 64 | Fill block |

## Verification
The embedded properties check the following on every cycle:
- the next-level request stays stable while it waits for `mem_ready`;
- a miss always drops `core_ready` on the following cycle;
- a hit always answers on the next cycle;
- a write-back is always followed by a fill;
- the response arrives two cycles after the fill handshake.

Whether the returned bytes are correct, which way is evicted, and whether a write-back carries the right block and data can only be shown by the bench scenarios. The bench compares against a flat byte-memory model and a shadow of the tag, valid, dirty and recency state. It runs a full read sweep, a long mixed load/store stream and same-set thrashing.

// File: rtl/wb_cache2.sv
module wb_cache2 #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        core_valid,
  input  logic                        core_write,
  input  logic [ADDR_W-1:0]           core_addr,
  input  logic [7:0]                  core_wdata,
  output logic                        core_ready,
  output logic                        rsp_valid,
  output logic [7:0]                  rsp_rdata,
  output logic                        mem_req_valid,
  output logic                        mem_req_write,
  output logic [ADDR_W-OFF_W-1:0]     mem_req_addr,
  output logic [(8<<OFF_W)-1:0]       mem_req_wdata,
  input  logic                        mem_ready,
  input  logic [(8<<OFF_W)-1:0]       mem_rdata
);
  localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
  localparam int SETS     = 1 << IDX_W;
  localparam int BLK_BITS = 8 << OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_DONE} st_t;
  st_t st;

  logic [BLK_BITS-1:0] data_q [SETS][2];
  logic [TAG_W-1:0]    tag_q  [SETS][2];
  logic [1:0]          valid_q [SETS];
  logic [1:0]          dirty_q [SETS];
  logic [SETS-1:0]     lru_q;

  logic              sv_write, sv_way;
  logic [ADDR_W-1:0] sv_addr;
  logic [7:0]        sv_wdata;

  wire [ADDR_W-1:0] cur_addr = (st == S_IDLE) ? core_addr : sv_addr;
  wire [TAG_W-1:0]  cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0]  cur_set  = cur_addr[OFF_W +: IDX_W];
  wire [OFF_W-1:0]  cur_off  = cur_addr[OFF_W-1:0];
  wire [IDX_W-1:0]  sv_set   = sv_addr[OFF_W +: IDX_W];

  wire hit0 = valid_q[cur_set][0] && (tag_q[cur_set][0] == cur_tag);
  wire hit1 = valid_q[cur_set][1] && (tag_q[cur_set][1] == cur_tag);
  wire hit  = hit0 | hit1;
  wire hway = hit1;

  wire victim = !valid_q[cur_set][0] ? 1'b0 :
                !valid_q[cur_set][1] ? 1'b1 : lru_q[cur_set];
  wire vic_dirty = valid_q[cur_set][victim] && dirty_q[cur_set][victim];

  assign core_ready = (st == S_IDLE);
  wire accept    = core_valid && core_ready;
  wire do_access = (accept && hit) || (st == S_DONE);
  wire acc_write = (st == S_DONE) ? sv_write : core_write;
  wire [7:0] acc_wdata = (st == S_DONE) ? sv_wdata : core_wdata;
  wire [7:0] rd_byte = data_q[cur_set][hway][{cur_off, 3'b000} +: 8];

  assign mem_req_valid = (st == S_WB) || (st == S_FILL);
  assign mem_req_write = (st == S_WB);
  assign mem_req_addr  = (st == S_WB) ? {tag_q[sv_set][sv_way], sv_set}
                                      : sv_addr[ADDR_W-1:OFF_W];
  assign mem_req_wdata = data_q[sv_set][sv_way];

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_ready) begin
      data_q[sv_set][sv_way] <= mem_rdata;
      tag_q[sv_set][sv_way]  <= sv_addr[ADDR_W-1 -: TAG_W];
    end else if (do_access && acc_write) begin
      data_q[cur_set][hway][{cur_off, 3'b000} +: 8] <= acc_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      lru_q     <= '0;
      sv_write  <= 1'b0;
      sv_way    <= 1'b0;
      sv_addr   <= '0;
      sv_wdata  <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      if (do_access) begin
        rsp_valid      <= 1'b1;
        rsp_rdata      <= acc_write ? acc_wdata : rd_byte;
        lru_q[cur_set] <= ~hway;
        if (acc_write) dirty_q[cur_set][hway] <= 1'b1;
      end
      case (st)
        S_IDLE: if (accept && !hit) begin
          sv_write <= core_write;
          sv_addr  <= core_addr;
          sv_wdata <= core_wdata;
          sv_way   <= victim;
          st       <= vic_dirty ? S_WB : S_FILL;
        end
        S_WB: if (mem_ready) st <= S_FILL;
        S_FILL: if (mem_ready) begin
          valid_q[sv_set][sv_way] <= 1'b1;
          dirty_q[sv_set][sv_way] <= 1'b0;
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  a_r4_miss_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> !core_ready);

  a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> rsp_valid);

  a_r5_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_ready) |=>
      (mem_req_valid && !mem_req_write));

  a_r4_fill_to_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write && mem_ready) |-> ##2 rsp_valid);
endmodule

// File: tb/wb_cache2_tb_top.sv
module wb_cache2_tb_top;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic core_valid = 0, core_write = 0;
  logic [7:0] core_addr = 0, core_wdata = 0;
  logic core_ready, rsp_valid, mem_req_valid, mem_req_write;
  logic [7:0] rsp_rdata;
  logic [4:0] mem_req_addr;
  logic [63:0] mem_req_wdata, mem_rdata = 0;
  logic mem_ready = 0;

  wb_cache2 dut_i (.clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_write(core_write),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_ready(core_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  int checks = 0, errors = 0;
  logic [7:0] backing [256];
  logic [7:0] refm [256];
  int fills = 0, wbs = 0, cnt = 0;
  logic [4:0] exp_fill_addr, exp_wb_addr;

  bit mv [4][2];
  bit md [4][2];
  bit ml [4];
  logic [2:0] mt [4][2];

  function automatic logic [63:0] blk_of(input logic [4:0] b, input bit use_ref);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = use_ref ? refm[{b, 3'(k)}] : backing[{b, 3'(k)}];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready <= 0;
      cnt <= 0;
    end else if (mem_req_valid) begin
      if (cnt == 2) begin
        mem_ready <= 1;
        if (mem_req_write) begin
          wbs++;
          chk(mem_req_addr == exp_wb_addr, "R7 write-back block", mem_req_addr, exp_wb_addr);
          chk(mem_req_wdata == blk_of(mem_req_addr, 1), "R5 write-back data",
              mem_req_wdata, blk_of(mem_req_addr, 1));
          for (int k = 0; k < 8; k++) backing[{mem_req_addr, 3'(k)}] = mem_req_wdata[8*k +: 8];
        end else begin
          fills++;
          chk(mem_req_addr == exp_fill_addr, "R2 fill block address", mem_req_addr, exp_fill_addr);
          mem_rdata <= blk_of(mem_req_addr, 0);
        end
      end else cnt <= cnt + 1;
    end
  end

  task automatic access(input logic [7:0] a, input bit we, input logic [7:0] wd);
    int s, t, lat, f0, w0, way;
    bit exp_hit, exp_wb, stall_ok;
    s = a[4:3]; t = a[7:5];
    @(negedge clk);
    while (!core_ready) @(negedge clk);
    exp_hit = (mv[s][0] && mt[s][0] == 3'(t)) || (mv[s][1] && mt[s][1] == 3'(t));
    way = (mv[s][1] && mt[s][1] == 3'(t)) ? 1 : 0;
    exp_wb = 0;
    if (!exp_hit) begin
      way = !mv[s][0] ? 0 : !mv[s][1] ? 1 : int'(ml[s]);
      exp_wb = mv[s][way] && md[s][way];
      exp_wb_addr = {mt[s][way], 2'(s)};
      exp_fill_addr = a[7:3];
    end
    f0 = fills; w0 = wbs;
    core_valid = 1; core_write = we; core_addr = a; core_wdata = wd;
    @(negedge clk);
    core_valid = 0;
    lat = 1; stall_ok = 1;
    while (!rsp_valid && lat < 60) begin
      if (core_ready) stall_ok = 0;
      @(negedge clk);
      lat++;
    end
    chk(rsp_valid, "R4 response arrives", rsp_valid, 1);
    if (exp_hit) begin
      chk(lat == 1, "R3 hit latency", lat, 1);
      chk(fills == f0 && wbs == w0, "R3 no memory traffic on hit", fills - f0 + wbs - w0, 0);
    end else begin
      chk(stall_ok, "R4 ready low during miss", stall_ok, 1);
      chk(fills == f0 + 1, "R7 miss predicted, one fill", fills - f0, 1);
      chk(wbs == w0 + int'(exp_wb), exp_wb ? "R5 dirty victim written back" : "R8 clean victim not written",
          wbs - w0, exp_wb);
      mv[s][way] = 1; md[s][way] = 0; mt[s][way] = 3'(t);
    end
    if (!we) chk(rsp_rdata == refm[a], we ? "R6" : "R3 load data", rsp_rdata, refm[a]);
    else begin
      refm[a] = wd;
      md[s][way] = 1;
    end
    ml[s] = ~way[0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      backing[i] = 8'(i) ^ 8'h5A;
      refm[i] = backing[i];
    end
    for (int s = 0; s < 4; s++) begin
      ml[s] = 0;
      for (int w = 0; w < 2; w++) begin mv[s][w] = 0; md[s][w] = 0; mt[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(core_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
        {core_ready, rsp_valid, mem_req_valid}, 3'b100);
    // R1 first access misses; R2 address fields via fill address
    access(8'hB5, 0, 0);
    for (int i = 0; i < 256; i++) access(8'(i), 0, 0);
    // R6 write-allocate miss followed by reads
    access(8'h13, 1, 8'hC3);
    access(8'h13, 0, 0);
    for (int i = 0; i < 900; i++)
      access(8'((i * 53 + (i >> 2) * 7) & 255), (i % 3) == 1, 8'(i * 13 + 5));
    // R7 thrash one set with three tags, stores make victims dirty (R5)
    for (int r = 0; r < 40; r++)
      access({3'(r % 3), 2'd2, 3'(r % 8)}, (r % 2) == 0, 8'(r + 100));
    for (int i = 0; i < 256; i++) access(8'(i), 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule